// File: doc/BRIEF.md
# Two-Network Credit Flow-Control Link Port

This block is one end-to-end link port between two network nodes, or between a node and its local endpoint. Two virtual networks, one for requests and one for responses, share a single physical flit wire in each direction. Each network has its own receive buffer and its own credit accounting. One network's traffic therefore never blocks the other's, even though both use the same wires.

On the transmit side, one credit counter per network starts at the far buffer's depth. A flit leaves only when its network holds at least one credit. When both networks are ready in the same cycle, a round-robin picker chooses which one drives the shared wire. The sent flit is registered onto the link together with a valid strobe and its network index.

On the receive side, each arriving flit is written into the buffer of the network it is tagged with. A credit tagged with that network goes back upstream only when the local consumer reads a flit out of the buffer, not when the flit arrives. Credits owed to both networks are returned one per cycle on a shared credit wire, again in round-robin order.

Top module: `ln_link_port`

## Requirements
- R1: After reset, the link valid, the credit-return valid and every buffer-available flag are low. Each network's credit counter holds the buffer depth (default 4), so a network can send exactly that many flits before any credit comes back.
- R2: A network's flit is accepted (`src_take` bit high) only in a cycle when that network holds a credit. A request with credit left is never refused unless the other network wins the same cycle.
- R3: A flit accepted in cycle t appears on the link in cycle t+1 with `lnk_out_valid` high, `lnk_out_vn` equal to the network index (0 or 1) and the same data. `lnk_out_valid` is low in every other cycle.
- R4: At most one network is accepted per cycle. When both request and both hold credit, the network not granted last wins, and network 0 wins the first such tie after reset.
- R5: Each network's receive buffer is first-in first-out and holds 4 flits. `dst_avail` is high exactly while that buffer is non-empty, and `dst_data` shows the oldest flit.
- R6: Each read out of a non-empty buffer causes exactly one credit return, tagged with that network. A read request on an empty buffer is ignored and returns nothing. Credit returns leave at most one per cycle, two cycles after the read when there is no contention.
- R7: When a network spends a credit and receives one in the same cycle, its count is unchanged.
- R8: When credits are owed to both networks, returns alternate between them, with network 0 first after reset.
- R9: No credit counter ever exceeds the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | VN_CNT | Per-network flit request from the local sender |
| src_data | input | VN_CNT*FLIT_W | Per-network flit data, network v at bits v*FLIT_W |
| src_take | output | VN_CNT | Flit of that network accepted this cycle |
| lnk_out_valid | output | 1 | Outgoing link carries a flit |
| lnk_out_vn | output | VW | Network index of the outgoing flit |
| lnk_out_data | output | FLIT_W | Outgoing flit data |
| crd_in_valid | input | 1 | Incoming credit return |
| crd_in_vn | input | VW | Network index of the incoming credit |
| lnk_in_valid | input | 1 | Incoming link carries a flit |
| lnk_in_vn | input | VW | Network index of the incoming flit |
| lnk_in_data | input | FLIT_W | Incoming flit data |
| crd_out_valid | output | 1 | Outgoing credit return |
| crd_out_vn | output | VW | Network index of the outgoing credit |
| dst_pop | input | VN_CNT | Local consumer reads the head flit of that network |
| dst_avail | output | VN_CNT | Buffer of that network is non-empty |
| dst_data | output | VN_CNT*FLIT_W | Head flit of each network's buffer |

## Verification
The bench ties the link and credit outputs back to the matching inputs, so the port acts as both ends of one link. It predicts each cycle exactly.

Acceptance is combinational and is judged in the cycle of the request. The flit is due on the link one cycle later and becomes visible in the buffer two cycles after acceptance. A read's credit return is due two cycles later when no other credit is owed. The sender's counter counts a returned credit from the cycle after the credit is seen.

The reference model advances its counters, buffer occupancies and round-robin pointers along these same delays. All outputs are sampled one nanosecond after the falling edge, so every comparison falls in the cycle in which that result is due.

// File: rtl/ln_link_pkg.sv
package ln_link_pkg;

  // index of the lowest set bit of a grant vector
  function automatic int oh_to_int(input logic [31:0] oh);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (oh[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/ln_credit_ctr.sv
module ln_credit_ctr #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spend_i,
  input  logic          ret_i,
  output logic [CW-1:0] cnt_o,
  output logic          has_o
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(DEPTH);
    end else begin
      case ({spend_i, ret_i})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign cnt_o = cnt;
  assign has_o = (cnt != '0);

endmodule

// File: rtl/ln_rr_pick.sv
module ln_rr_pick #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  logic [IW-1:0] last, last_n;
  logic          found;

  always_comb begin
    gnt_o  = '0;
    found  = 1'b0;
    last_n = last;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (int'(last) + 1 + i) % N;
      if (!found && req_i[k]) begin
        gnt_o[k] = 1'b1;
        found    = 1'b1;
        last_n   = IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else     last <= last_n;
  end

endmodule

// File: rtl/ln_vn_fifo.sv
module ln_vn_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         avail,
  output logic         full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == (AW + 1)'(DEPTH));
  assign avail = (cnt != '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && avail;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/ln_link_port.sv
module ln_link_port
  import ln_link_pkg::*;
#(
  parameter int VN_CNT    = 2,
  parameter int FLIT_W    = 32,
  parameter int BUF_DEPTH = 4,
  localparam int VW = (VN_CNT > 1) ? $clog2(VN_CNT) : 1,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VN_CNT-1:0]        src_valid,
  input  logic [VN_CNT*FLIT_W-1:0] src_data,
  output logic [VN_CNT-1:0]        src_take,
  output logic                     lnk_out_valid,
  output logic [VW-1:0]            lnk_out_vn,
  output logic [FLIT_W-1:0]        lnk_out_data,
  input  logic                     crd_in_valid,
  input  logic [VW-1:0]            crd_in_vn,
  input  logic                     lnk_in_valid,
  input  logic [VW-1:0]            lnk_in_vn,
  input  logic [FLIT_W-1:0]        lnk_in_data,
  output logic                     crd_out_valid,
  output logic [VW-1:0]            crd_out_vn,
  input  logic [VN_CNT-1:0]        dst_pop,
  output logic [VN_CNT-1:0]        dst_avail,
  output logic [VN_CNT*FLIT_W-1:0] dst_data
);

  localparam int PW = $clog2(BUF_DEPTH + 1);

  // transmit side
  logic [VN_CNT-1:0]    tx_has, tx_req, tx_gnt;
  logic [VN_CNT*CW-1:0] crd_cnt_flat;
  logic [FLIT_W-1:0]    tx_sel;

  for (genvar v = 0; v < VN_CNT; v++) begin : g_tx
    ln_credit_ctr #(.DEPTH(BUF_DEPTH)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .spend_i (tx_gnt[v]),
      .ret_i   (crd_in_valid && (crd_in_vn == VW'(v))),
      .cnt_o   (crd_cnt_flat[v*CW +: CW]),
      .has_o   (tx_has[v])
    );
  end

  assign tx_req   = src_valid & tx_has;
  assign src_take = tx_gnt;

  ln_rr_pick #(.N(VN_CNT)) u_tx_arb (
    .clk   (clk),
    .rst   (rst),
    .req_i (tx_req),
    .gnt_o (tx_gnt)
  );

  always_comb begin
    tx_sel = '0;
    for (int v = 0; v < VN_CNT; v++) begin
      if (tx_gnt[v]) tx_sel = src_data[v*FLIT_W +: FLIT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_out_valid <= 1'b0;
      lnk_out_vn    <= '0;
      lnk_out_data  <= '0;
    end else begin
      lnk_out_valid <= |tx_gnt;
      lnk_out_vn    <= VW'(oh_to_int(32'(tx_gnt)));
      lnk_out_data  <= tx_sel;
    end
  end

  // receive side
  logic [VN_CNT-1:0] rx_rd, cr_req, cr_gnt, buf_full;
  logic [PW-1:0]     owed [VN_CNT];

  for (genvar v = 0; v < VN_CNT; v++) begin : g_rx
    assign rx_rd[v]  = dst_pop[v] && dst_avail[v];
    assign cr_req[v] = (owed[v] != '0);

    ln_vn_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (lnk_in_valid && (lnk_in_vn == VW'(v))),
      .wr_data (lnk_in_data),
      .rd_en   (rx_rd[v]),
      .rd_data (dst_data[v*FLIT_W +: FLIT_W]),
      .avail   (dst_avail[v]),
      .full    (buf_full[v])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        owed[v] <= '0;
      end else begin
        case ({rx_rd[v], cr_gnt[v]})
          2'b10:   owed[v] <= owed[v] + 1'b1;
          2'b01:   owed[v] <= owed[v] - 1'b1;
          default: owed[v] <= owed[v];
        endcase
      end
    end
  end

  ln_rr_pick #(.N(VN_CNT)) u_cr_arb (
    .clk   (clk),
    .rst   (rst),
    .req_i (cr_req),
    .gnt_o (cr_gnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crd_out_valid <= 1'b0;
      crd_out_vn    <= '0;
    end else begin
      crd_out_valid <= |cr_gnt;
      crd_out_vn    <= VW'(oh_to_int(32'(cr_gnt)));
    end
  end

endmodule

// File: rtl/ln_link_port_chk.sv
module ln_link_port_chk #(
  parameter int VN_CNT    = 2,
  parameter int BUF_DEPTH = 4,
  parameter int CW        = 3,
  parameter int VW        = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [VN_CNT-1:0]    src_take,
  input logic                 lnk_out_valid,
  input logic                 crd_out_valid,
  input logic                 crd_in_valid,
  input logic [VW-1:0]        crd_in_vn,
  input logic                 lnk_in_valid,
  input logic [VW-1:0]        lnk_in_vn,
  input logic [VN_CNT*CW-1:0] crd_cnt_flat,
  input logic [VN_CNT-1:0]    buf_full
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lnk_out_valid && !crd_out_valid));

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_take));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_take) |=> lnk_out_valid);

  // R3
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !(|src_take) |=> !lnk_out_valid);

  for (genvar v = 0; v < VN_CNT; v++) begin : g_vn
    // R9
    credit_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
      crd_cnt_flat[v*CW +: CW] <= CW'(BUF_DEPTH));

    // R2
    credit_gate_chk: assert property (@(posedge clk) disable iff (rst)
      src_take[v] |-> (crd_cnt_flat[v*CW +: CW] != '0));

    // R7
    credit_balance_chk: assert property (@(posedge clk) disable iff (rst)
      (src_take[v] && crd_in_valid && (crd_in_vn == VW'(v)))
      |=> $stable(crd_cnt_flat[v*CW +: CW]));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (lnk_in_valid && (lnk_in_vn == VW'(v))) |-> !buf_full[v]);
  end

endmodule

bind ln_link_port ln_link_port_chk #(
  .VN_CNT(VN_CNT), .BUF_DEPTH(BUF_DEPTH), .CW(CW), .VW(VW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .src_take      (src_take),
  .lnk_out_valid (lnk_out_valid),
  .crd_out_valid (crd_out_valid),
  .crd_in_valid  (crd_in_valid),
  .crd_in_vn     (crd_in_vn),
  .lnk_in_valid  (lnk_in_valid),
  .lnk_in_vn     (lnk_in_vn),
  .crd_cnt_flat  (crd_cnt_flat),
  .buf_full      (buf_full)
);

// File: tb/ln_link_port_test.sv
`timescale 1ns/1ps
module ln_link_port_test;
  localparam int VN = 2;
  localparam int FW = 32;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [VN-1:0]    src_valid = '0;
  logic [VN*FW-1:0] src_data = '0;
  logic [VN-1:0]    src_take;
  logic             lnk_out_valid;
  logic [0:0]       lnk_out_vn;
  logic [FW-1:0]    lnk_out_data;
  logic             crd_out_valid;
  logic [0:0]       crd_out_vn;
  logic [VN-1:0]    dst_pop = '0;
  logic [VN-1:0]    dst_avail;
  logic [VN*FW-1:0] dst_data;

  ln_link_port #(.VN_CNT(VN), .FLIT_W(FW), .BUF_DEPTH(DEP)) uut (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_data(src_data), .src_take(src_take),
    .lnk_out_valid(lnk_out_valid), .lnk_out_vn(lnk_out_vn), .lnk_out_data(lnk_out_data),
    .crd_in_valid(crd_out_valid), .crd_in_vn(crd_out_vn),
    .lnk_in_valid(lnk_out_valid), .lnk_in_vn(lnk_out_vn), .lnk_in_data(lnk_out_data),
    .crd_out_valid(crd_out_valid), .crd_out_vn(crd_out_vn),
    .dst_pop(dst_pop), .dst_avail(dst_avail), .dst_data(dst_data)
  );

  int tests = 0;
  int fails = 0;

  // reference model state
  int          mcnt [VN];
  int          rx_cnt [VN];
  int          owed [VN];
  int          last_g, clast;
  bit          exp_lnk_valid, exp_cr_valid;
  int          exp_lnk_vn, exp_cr_vn;
  logic [31:0] exp_lnk_data;
  logic [31:0] q [VN][256];
  int          wp [VN];
  int          rp [VN];
  logic [VN-1:0] t_take;
  bit          t_cr;
  int          t_cr_vn;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < VN; v++) begin
      mcnt[v] = DEP; rx_cnt[v] = 0; owed[v] = 0; wp[v] = 0; rp[v] = 0;
    end
    last_g = 1; clast = 1;
    exp_lnk_valid = 0; exp_lnk_vn = 0; exp_lnk_data = '0;
    exp_cr_valid = 0; exp_cr_vn = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_valid = '0; dst_pop = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic tick(input logic [VN-1:0] sv, input logic [VN-1:0] pr);
    logic [VN-1:0] el, et, pe, cg;
    int tk;
    @(negedge clk);
    src_valid = sv;
    for (int v = 0; v < VN; v++) src_data[v*FW +: FW] = $urandom;
    dst_pop = pr;
    #1;
    // acceptance: R2 / R4
    for (int v = 0; v < VN; v++) el[v] = sv[v] && (mcnt[v] > 0);
    if (el == 2'b11) et = (last_g == 0) ? 2'b10 : 2'b01;
    else             et = el;
    chk(src_take == et, (el == 2'b11) ? "R4" : "R2", 64'(src_take), 64'(et));
    t_take = src_take;
    // link output: R3
    chk(lnk_out_valid == exp_lnk_valid, "R3", 64'(lnk_out_valid), 64'(exp_lnk_valid));
    if (exp_lnk_valid) begin
      chk(int'(lnk_out_vn) == exp_lnk_vn, "R3", 64'(lnk_out_vn), 64'(exp_lnk_vn));
      chk(lnk_out_data == exp_lnk_data, "R3", 64'(lnk_out_data), 64'(exp_lnk_data));
    end
    // buffers: R5
    for (int v = 0; v < VN; v++) begin
      chk(dst_avail[v] == (rx_cnt[v] != 0), "R5", 64'(dst_avail[v]), 64'(rx_cnt[v] != 0));
      pe[v] = pr[v] && (rx_cnt[v] != 0);
      if (pe[v])
        chk(dst_data[v*FW +: FW] == q[v][rp[v]], "R5", 64'(dst_data[v*FW +: FW]), 64'(q[v][rp[v]]));
    end
    // credit return: R6 / R8
    chk(crd_out_valid == exp_cr_valid, "R6", 64'(crd_out_valid), 64'(exp_cr_valid));
    if (exp_cr_valid)
      chk(int'(crd_out_vn) == exp_cr_vn, "R8", 64'(crd_out_vn), 64'(exp_cr_vn));
    t_cr = crd_out_valid; t_cr_vn = int'(crd_out_vn);
    // model advance
    if (exp_cr_valid) mcnt[exp_cr_vn]++;
    if (exp_lnk_valid) rx_cnt[exp_lnk_vn]++;
    exp_lnk_valid = 0;
    tk = -1;
    for (int v = 0; v < VN; v++) if (et[v]) tk = v;
    if (tk >= 0) begin
      mcnt[tk]--; last_g = tk;
      exp_lnk_valid = 1; exp_lnk_vn = tk;
      exp_lnk_data = src_data[tk*FW +: FW];
      q[tk][wp[tk]] = exp_lnk_data; wp[tk] = (wp[tk] + 1) & 255;
    end
    for (int v = 0; v < VN; v++) cg[v] = (owed[v] > 0);
    exp_cr_valid = 0;
    if (cg != '0) begin
      exp_cr_valid = 1;
      if (cg == 2'b11) exp_cr_vn = (clast == 0) ? 1 : 0;
      else             exp_cr_vn = cg[1] ? 1 : 0;
      owed[exp_cr_vn]--; clast = exp_cr_vn;
    end
    for (int v = 0; v < VN; v++) if (pe[v]) begin
      rx_cnt[v]--; owed[v]++; rp[v] = (rp[v] + 1) & 255;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0, n1, c0, c1;
    void'($urandom(32'd41));
    model_reset();

    // R1: quiet after reset, credits full
    do_reset();
    tick(2'b00, 2'b00);
    chk(!lnk_out_valid && !crd_out_valid && dst_avail == '0, "R1",
        64'({lnk_out_valid, crd_out_valid, dst_avail}), 64'd0);
    n0 = 0;
    for (int i = 0; i < 8; i++) begin
      tick(2'b01, 2'b00);
      if (t_take[0]) n0++;
    end
    chk(n0 == DEP, "R1", 64'(n0), 64'(DEP));   // R2: stall after depth
    tick(2'b01, 2'b00);
    chk(t_take == 2'b00, "R2", 64'(t_take), 64'd0);

    // R4: both networks tie, alternation
    do_reset();
    n0 = 0; n1 = 0;
    for (int i = 0; i < 10; i++) begin
      tick(2'b11, 2'b00);
      if (i == 0) chk(t_take == 2'b01, "R4", 64'(t_take), 64'd1);
      if (i == 1) chk(t_take == 2'b10, "R4", 64'(t_take), 64'd2);
      n0 += t_take[0]; n1 += t_take[1];
    end
    chk(n0 == 4 && n1 == 4, "R4", 64'({n0[15:0], n1[15:0]}), 64'h00040004);

    // R8 / R6: drain both, credits alternate, one per read
    c0 = 0; c1 = 0;
    for (int i = 0; i < 14; i++) begin
      tick(2'b00, 2'b11);
      if (t_cr) begin
        if (t_cr_vn == 0) c0++; else c1++;
      end
    end
    chk(c0 == 4 && c1 == 4, "R6", 64'({c0[15:0], c1[15:0]}), 64'h00040004);

    // R6: reads on empty buffers return nothing
    c0 = 0;
    for (int i = 0; i < 6; i++) begin
      tick(2'b00, 2'b11);
      if (t_cr) c0++;
    end
    chk(c0 == 0, "R6", 64'(c0), 64'd0);

    // R7: streaming with concurrent spend and return, then count intact
    for (int i = 0; i < 40; i++) tick(2'b01, 2'b01);
    for (int i = 0; i < 12; i++) tick(2'b00, 2'b01);
    n0 = 0;
    for (int i = 0; i < 8; i++) begin
      tick(2'b01, 2'b00);
      n0 += t_take[0];
    end
    chk(n0 == DEP, "R7", 64'(n0), 64'(DEP));
    for (int i = 0; i < 10; i++) tick(2'b00, 2'b11);

    // random traffic, R9 bounded credits via exact model
    for (int i = 0; i < 3000; i++) tick(2'($urandom), 2'($urandom));
    for (int i = 0; i < 20; i++) tick(2'b00, 2'b11);
    chk(mcnt[0] == DEP && mcnt[1] == DEP, "R9", 64'({mcnt[0][15:0], mcnt[1][15:0]}), 64'h00040004);
    n0 = 0; n1 = 0;
    for (int i = 0; i < 12; i++) begin
      tick(2'b11, 2'b00);
      n0 += t_take[0]; n1 += t_take[1];
    end
    chk(n0 == DEP && n1 == DEP, "R9", 64'({n0[15:0], n1[15:0]}), 64'h00040004);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule